// File: doc/BRIEF.md
# T1 Transmit Idle and Per-Channel Loopback Inserter

This block sits in the serial transmit path of a T1 framer. It follows a 193-bit frame (one framing bit, then 24 channel time slots of 8 bits each) with a bit-enable strobe and a frame-sync pulse. For every channel it decides, at the first bit of the slot, whether the slot passes the transmit serial data unchanged or is substituted for the whole slot.

What the substitution is depends on a mode input. In idle mode, a marked channel carries a programmable 8-bit idle code, most significant bit first. In loopback mode, the same per-channel marks select the serial data coming out of the receive-side framer instead. The framing bit is never touched. Four 8-bit registers program the block: three hold the 24-bit channel mask, and the fourth holds the idle code. Register writes and mode changes that arrive in the middle of a slot take effect at the next slot boundary, so a channel byte is never partly replaced.

Top module: `t1_idle_insert`

## Requirements
- R1: The framing bit (the bit presented with `fsync` high, or the bit after channel 24's last bit) is passed from `tx_ser_in` to `tx_ser_out` unchanged.
- R2: A channel whose mask bit is 0 passes all 8 bits of `tx_ser_in` unchanged, in either mode.
- R3: Mask address 0 bit k marks channel k+1 (channels 1 to 8), address 1 bit k marks channel k+9, and address 2 bit k marks channel k+17; a higher channel number sits at a higher bit.
- R4: With `loop_mode` low and the channel's mask bit 1, the slot carries the idle code, bit 7 in the slot's first bit time down to bit 0 in its last.
- R5: A write to address 3 sets the idle code.
- R6: With `loop_mode` high and the channel's mask bit 1, the slot carries `rx_ser_in`. The idle code is not used.
- R7: A register write that lands inside a channel slot does not change that slot. It first applies to the slot that starts after the write.
- R8: A change of `loop_mode` inside a channel slot does not change that slot. The mode is sampled at the slot's first bit.
- R9: `tx_ser_out` is registered and presents each bit one clock after the clock in which it was taken with `bit_en` high. While `bit_en` is low, the output and the frame position hold.
- R10: `fsync` with `bit_en` high marks the framing bit at any time and restarts the frame position from there.
- R11: After synchronous reset, `tx_ser_out` is 0, all mask bits are 0, the idle code is 0x7F, and the next bit is taken as a framing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One serial bit is taken in this clock |
| fsync | input | 1 | Marks the framing bit (qualified by bit_en) |
| loop_mode | input | 1 | 0: marked channels carry the idle code; 1: marked channels carry receive data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0..2 mask bytes, 3 idle code |
| wr_data | input | 8 | Register write data |
| tx_ser_in | input | 1 | Transmit serial data |
| rx_ser_in | input | 1 | Receive-framer serial data for loopback |
| tx_ser_out | output | 1 | Transmit serial data after substitution |

## Verification
A register write or a mode change can land in the same clock as a channel slot's first bit, or in the middle of a slot. In both cases the new setting must wait for a slot boundary. The bench places mask and idle writes and mode flips at bit positions in the middle of a slot and on a first bit. It also inserts random `bit_en` gaps. A bench model updates its own register copy only after it has worked out the current bit, so every output bit is compared against a value built from the rule that a slot's choice is fixed when its first bit is seen.

// File: rtl/t1_ins_pkg.sv
package t1_ins_pkg;
  localparam int CH_NUM    = 24;
  localparam int CH_BITS   = 8;
  localparam int REG_W     = 8;
  localparam int MASK_REGS = (CH_NUM + REG_W - 1) / REG_W;
  localparam int ADDR_W    = $clog2(MASK_REGS + 1);
  localparam int CH_IDX_W  = $clog2(CH_NUM);
  localparam int BIT_IDX_W = $clog2(CH_BITS);
  localparam logic [CH_BITS-1:0] IDLE_RST = 8'h7F;

  typedef struct packed {
    logic                 fbit;
    logic [CH_IDX_W-1:0]  ch;
    logic [BIT_IDX_W-1:0] bidx;
  } slot_pos_t;
endpackage

// File: rtl/t1_slot_counter.sv
module t1_slot_counter
  import t1_ins_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bit_en,
  input  logic      fsync,
  output slot_pos_t pos
);
  localparam logic [CH_IDX_W-1:0]  LAST_CH  = CH_IDX_W'(CH_NUM - 1);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(CH_BITS - 1);

  logic                 at_fbit_q;
  logic [CH_IDX_W-1:0]  ch_q;
  logic [BIT_IDX_W-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      at_fbit_q <= 1'b1;
      ch_q      <= '0;
      bit_q     <= '0;
    end else if (bit_en) begin
      if (fsync || at_fbit_q) begin
        at_fbit_q <= 1'b0;
        ch_q      <= '0;
        bit_q     <= '0;
      end else if (bit_q == LAST_BIT) begin
        bit_q <= '0;
        if (ch_q == LAST_CH) at_fbit_q <= 1'b1;
        else                 ch_q      <= ch_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  always_comb begin
    pos.fbit = fsync || at_fbit_q;
    pos.ch   = ch_q;
    pos.bidx = bit_q;
  end

  // R10: counters stay inside a legal slot position
  p_pos_range_r10: assert property (@(posedge clk) disable iff (rst)
    (ch_q <= LAST_CH) && (bit_q <= LAST_BIT));

  // R10: a frame sync restarts at channel 1, bit 0
  p_fsync_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (bit_en && fsync) |=> (ch_q == '0 && bit_q == '0 && !at_fbit_q));

  // R9: without a bit strobe the position holds
  p_pos_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(ch_q) && $stable(bit_q) && $stable(at_fbit_q)));
endmodule

// File: rtl/t1_cfg_regs.sv
module t1_cfg_regs
  import t1_ins_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  output logic [CH_NUM-1:0]  mask,
  output logic [CH_BITS-1:0] idle_code
);
  localparam logic [ADDR_W-1:0] IDLE_ADDR = ADDR_W'(MASK_REGS);

  logic [MASK_REGS*REG_W-1:0] mask_flat;

  for (genvar r = 0; r < MASK_REGS; r++) begin : g_mask
    logic [REG_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)                                  byte_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(r))  byte_q <= wr_data;
    end
    assign mask_flat[r*REG_W +: REG_W] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                                idle_code <= IDLE_RST;
    else if (wr_en && wr_addr == IDLE_ADDR) idle_code <= wr_data[CH_BITS-1:0];
  end

  assign mask = mask_flat[CH_NUM-1:0];

  // R5: the idle register takes the data written to the address after the mask
  p_idle_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == IDLE_ADDR) |=> (idle_code == $past(wr_data[CH_BITS-1:0])));

  // R3: a write elsewhere leaves the idle code alone
  p_idle_keep_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == IDLE_ADDR) |=> $stable(idle_code));
endmodule

// File: rtl/t1_slot_mux.sv
module t1_slot_mux
  import t1_ins_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_en,
  input  slot_pos_t          pos,
  input  logic [CH_NUM-1:0]  mask,
  input  logic [CH_BITS-1:0] idle_code,
  input  logic               loop_mode,
  input  logic               tx_in,
  input  logic               rx_in,
  output logic               tx_out
);
  localparam logic [BIT_IDX_W-1:0] MSB_IDX = BIT_IDX_W'(CH_BITS - 1);

  logic               ins_q, lb_q;
  logic [CH_BITS-1:0] code_q;
  logic               first;
  logic               ins_now, lb_now, nxt;
  logic [CH_BITS-1:0] code_now;

  assign first = !pos.fbit && (pos.bidx == '0);

  always_comb begin
    ins_now  = first ? mask[pos.ch] : ins_q;
    lb_now   = first ? loop_mode    : lb_q;
    code_now = first ? idle_code    : code_q;
    if (pos.fbit || !ins_now) nxt = tx_in;
    else if (lb_now)          nxt = rx_in;
    else                      nxt = code_now[MSB_IDX - pos.bidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_out <= 1'b0;
      ins_q  <= 1'b0;
      lb_q   <= 1'b0;
      code_q <= '0;
    end else if (bit_en) begin
      tx_out <= nxt;
      if (first) begin
        ins_q  <= ins_now;
        lb_q   <= lb_now;
        code_q <= code_now;
      end
    end
  end

  // R7, R8: the slot decision is frozen between slot boundaries
  p_slot_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    !(bit_en && first) |=> ($stable(ins_q) && $stable(lb_q) && $stable(code_q)));

  // R1: the framing bit is copied through with one clock of latency
  p_fbit_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_en && pos.fbit) |=> (tx_out == $past(tx_in)));

  // R9: output holds while no bit is strobed
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_out));
endmodule

// File: rtl/t1_idle_insert.sv
module t1_idle_insert
  import t1_ins_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic              loop_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              tx_ser_in,
  input  logic              rx_ser_in,
  output logic              tx_ser_out
);
  slot_pos_t          pos;
  logic [CH_NUM-1:0]  mask;
  logic [CH_BITS-1:0] idle_code;

  t1_slot_counter u_cnt (
    .clk    (clk),
    .rst    (rst),
    .bit_en (bit_en),
    .fsync  (fsync),
    .pos    (pos)
  );

  t1_cfg_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mask      (mask),
    .idle_code (idle_code)
  );

  t1_slot_mux u_mux (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .pos       (pos),
    .mask      (mask),
    .idle_code (idle_code),
    .loop_mode (loop_mode),
    .tx_in     (tx_ser_in),
    .rx_in     (rx_ser_in),
    .tx_out    (tx_ser_out)
  );

  // R2: an unmarked channel bit is copied straight through
  p_unmarked_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !pos.fbit && pos.bidx == '0 && !mask[pos.ch]) |=> (tx_ser_out == $past(tx_ser_in)));
endmodule

// File: tb/t1_idle_insert_test.sv
module t1_idle_insert_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0, fsync = 1'b0, loop_mode = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tx_ser_in = 1'b0, rx_ser_in = 1'b0;
  logic       tx_ser_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench reference state
  bit        m_at_f;
  int        m_ch, m_bit;
  bit [23:0] m_mask;
  bit [7:0]  m_idle;
  bit        m_ins, m_lb;
  bit [7:0]  m_code;
  bit        m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  t1_idle_insert uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .fsync(fsync), .loop_mode(loop_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_ser_in(tx_ser_in), .rx_ser_in(rx_ser_in), .tx_ser_out(tx_ser_out)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tx_ser_out=%0b expected %0b (ch=%0d bit=%0d)", tag, act, exp, m_ch, m_bit);
    end
  endtask

  function automatic void model_reset();
    m_at_f = 1; m_ch = 0; m_bit = 0; m_mask = '0; m_idle = 8'h7F;
    m_ins = 0; m_lb = 0; m_code = '0; m_out = 0;
  endfunction

  // one clock: compute the expected bit from the requirements, then apply writes
  task automatic step(input bit fs, input bit be, input bit txb, input bit rxb, input bit md,
                      input bit we, input bit [1:0] wa, input bit [7:0] wd, input string tag);
    bit    exp;
    string t;
    @(negedge clk);
    fsync = fs; bit_en = be; tx_ser_in = txb; rx_ser_in = rxb; loop_mode = md;
    wr_en = we; wr_addr = wa; wr_data = wd;
    exp = m_out;
    t = "R9";
    if (be) begin
      if (fs || m_at_f) begin
        exp = txb; t = "R1";
        m_at_f = 0; m_ch = 0; m_bit = 0;
      end else begin
        if (m_bit == 0) begin
          m_ins = m_mask[m_ch]; m_lb = md; m_code = m_idle;
        end
        if (!m_ins)    begin exp = txb;             t = "R2"; end
        else if (m_lb) begin exp = rxb;             t = "R6"; end
        else           begin exp = m_code[7-m_bit]; t = "R4"; end
        if (m_bit == 7) begin
          m_bit = 0;
          if (m_ch == 23) m_at_f = 1; else m_ch++;
        end else m_bit++;
      end
    end
    if (we) begin
      if (wa == 2'd3) m_idle = wd;
      else m_mask[wa*8 +: 8] = wd;
    end
    if (tag != "") t = tag;
    m_out = exp;
    @(posedge clk); #1;
    check(tx_ser_out, exp, t);
  endtask

  task automatic reg_write(input bit [1:0] wa, input bit [7:0] wd, input string tag);
    step(0, 0, 0, 0, loop_mode, 1, wa, wd, tag);
  endtask

  task automatic run_frame(input bit md_a, input bit md_b, input int sw_pos, input int wr_pos,
                           input bit [1:0] wa, input bit [7:0] wd, input int gap_pct, input string tag);
    for (int p = 0; p < 193; p++) begin
      if (gap_pct > 0 && ($urandom % 100) < gap_pct)
        step(0, 0, 1'($urandom), 1'($urandom), md_a, 0, 0, 0, "R9");
      step(p == 0, 1, 1'($urandom), 1'($urandom), (p >= sw_pos) ? md_b : md_a,
           p == wr_pos, wa, wd, tag);
    end
  endtask

  task automatic run_bits(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(0, 1, 1'($urandom), 1'($urandom), loop_mode, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check(tx_ser_out, 1'b0, "R11");          // R11: output low in reset
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check(tx_ser_out, 1'b0, "R11");

    // R11: reset idle code 0x7F, first bit taken as framing bit even without fsync
    reg_write(2'd0, 8'h01, "R9");
    run_bits(1, "R11");
    run_bits(192, "R11");

    // R3, R5: edges of each mask byte, new idle code
    reg_write(2'd3, 8'hA5, "R5");
    reg_write(2'd0, 8'h81, "R3");
    reg_write(2'd1, 8'h80, "R3");
    reg_write(2'd2, 8'h81, "R3");
    run_frame(0, 0, 999, -1, 0, 0, 0, "R3");
    run_frame(0, 0, 999, -1, 0, 0, 0, "");

    // R6: loopback mode with the same marks
    run_frame(1, 1, 999, -1, 0, 0, 0, "R6");

    // R7: mask write inside channel 3, write of idle code on the first bit of channel 5
    reg_write(2'd0, 8'h00, "R9");
    run_frame(0, 0, 999, 1 + 2*8 + 3, 2'd0, 8'h3C, 0, "R7");
    run_frame(0, 0, 999, 1 + 4*8, 2'd3, 8'h5A, 0, "R7");
    run_frame(0, 0, 999, 1 + 5*8 + 7, 2'd1, 8'hFF, 0, "R7");

    // R8: mode flips mid-slot and on a slot's first bit
    run_frame(0, 1, 1 + 3*8 + 4, -1, 0, 0, 0, "R8");
    run_frame(1, 0, 1 + 9*8, -1, 0, 0, 0, "R8");

    // R9: random bit-enable gaps
    run_frame(0, 0, 999, -1, 0, 0, 30, "");
    run_frame(1, 1, 999, -1, 0, 0, 30, "");

    // R10: resync after a partial frame
    run_bits(77, "R10");
    run_frame(0, 0, 999, -1, 0, 0, 0, "R10");

    // random configurations
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 4; a++) reg_write(2'(a), 8'($urandom), "R9");
      run_frame(1'($urandom), 1'($urandom), $urandom % 193, $urandom % 193,
                2'($urandom), 8'($urandom), 15, "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule